// File: doc/BRIEF.md
# Store-and-Compare Single-Cycle Core

This block is a 32-bit single-cycle processor core with exactly two instructions. The first stores a register to data memory at a base register plus a sign-extended 16-bit offset. The second is a three-register instruction that compares its source register with the address of the instruction being executed. If they are equal, control jumps to the value in a second register and the source value is copied into the destination. If they differ, the destination is loaded from data memory at the address held in the source register, and execution continues with the next word.

Each instruction completes in one clock cycle. The core holds the program counter, a register file, an adder/subtractor with a zero flag, and the 2-to-1 selects that this instruction pair needs. Instruction memory and data memory are word arrays inside the block. While reset is held, the memories are filled through a load port. Debug read ports expose the program counter, any register and any memory word, so a bench can follow execution one cycle at a time.

Top module: `dual_op_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register becomes 0. No instruction has any effect during such a cycle.
- R2: An instruction whose bits 31:26 are neither 000000 nor 100000 does nothing except advance the program counter by 4. No register or data memory word changes.
- R3: Opcode 000000 (rs in bits 25:21, rt in bits 20:16, offset in bits 15:0) writes register rt into the data word at rs + offset at the rising edge. It writes no register and advances the program counter by 4.
- R4: The store offset is sign-extended, so offset 0xFFFC subtracts 4 from the base register.
- R5: Opcode 100000 (rs 25:21, rt 20:16, rd 15:11) with register rs equal to the program counter sets the next program counter to the value of register rt and writes the value of rs into rd.
- R6: Opcode 100000 with register rs different from the program counter writes into rd the data word addressed by the value of rs, and advances the program counter by 4.
- R7: Register 0 always reads 0. A write to it is discarded.
- R8: Data memory is indexed by address bits [MEM_AW+1:2], so the address is taken modulo the memory size and bits 1:0 are ignored. Instruction fetch uses the same bits of the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Writes `load_word` into a memory at the next edge |
| load_dmem | input | 1 | Load target: 1 selects data memory, 0 selects instruction memory |
| load_idx | input | MEM_AW | Word index for the load |
| load_word | input | XLEN | Word to load |
| dbg_pc | output | XLEN | Current program counter |
| dbg_reg_sel | input | clog2(NREGS) | Register selected for the debug read |
| dbg_reg_val | output | XLEN | Value of the selected register |
| dbg_mem_idx | input | MEM_AW | Word index for the debug memory reads |
| dbg_mem_val | output | XLEN | Data memory word at `dbg_mem_idx` |
| dbg_imem_val | output | XLEN | Instruction memory word at `dbg_mem_idx` |

## Verification
Each instruction is fetched and decoded combinationally from the current program counter. Its register write, memory write and new program counter all take effect at the next rising edge, so every result is due one edge after the instruction becomes current. The bench steps its own architectural model once per cycle. It compares the program counter, every register and every data memory word at the falling edge after that rising edge, so each comparison falls half a cycle after the result appears and half a cycle before the next update. Reset and memory loading are checked at falling edges while reset is held.

// File: rtl/dcore_pkg.sv
package dcore_pkg;

   localparam logic [5:0] OP_STORE = 6'b000000;
   localparam logic [5:0] OP_PCCMP = 6'b100000;

   typedef struct packed {
      logic pc_from_reg;
      logic wb_from_mem;
      logic addr_from_reg;
      logic rf_we;
      logic mem_we;
   } dcore_ctrl_t;

   function automatic logic [4:0] fld_rs(input logic [31:0] ins);
      return ins[25:21];
   endfunction

   function automatic logic [4:0] fld_rt(input logic [31:0] ins);
      return ins[20:16];
   endfunction

   function automatic logic [4:0] fld_rd(input logic [31:0] ins);
      return ins[15:11];
   endfunction

endpackage

// File: rtl/dcore_ctrl.sv
module dcore_ctrl
   import dcore_pkg::*;
#(
   parameter bit STRICT_DECODE = 1'b1
)(
   input  logic [5:0]  opcode,
   input  logic        zero,
   output logic        alu_b_imm,
   output dcore_ctrl_t ctl
);

   logic known;

   generate
      if (STRICT_DECODE) begin : g_strict
         assign known = (opcode == OP_STORE) || (opcode == OP_PCCMP);
      end else begin : g_loose
         assign known = 1'b1;
      end
   endgenerate

   // ALU operand select depends on the opcode only, never on the zero flag.
   assign alu_b_imm = ~opcode[5];

   always_comb begin
      ctl.pc_from_reg   = known &  opcode[5] &  zero;
      ctl.wb_from_mem   = known &  opcode[5] & ~zero;
      ctl.addr_from_reg = known &  opcode[5] & ~zero;
      ctl.rf_we         = known &  opcode[5];
      ctl.mem_we        = known & ~opcode[5];
   end

endmodule

// File: rtl/dcore_alu.sv
module dcore_alu #(
   parameter int XLEN = 32
)(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            sub,
   output logic [XLEN-1:0] y,
   output logic            zero
);

   always_comb begin
      y    = sub ? (a - b) : (a + b);
      zero = (y == '0);
   end

endmodule

// File: rtl/dcore_regfile.sv
module dcore_regfile #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   localparam int RW   = $clog2(NREGS)
)(
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [RW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   input  logic [RW-1:0]   ra1,
   output logic [XLEN-1:0] rd1,
   input  logic [RW-1:0]   ra2,
   output logic [XLEN-1:0] rd2,
   input  logic [RW-1:0]   ra3,
   output logic [XLEN-1:0] rd3
);

   logic [XLEN-1:0] regs [NREGS];

   assign regs[0] = '0;

   generate
      for (genvar i = 1; i < NREGS; i++) begin : g_reg
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && (wa == RW'(i)))
               q <= wd;
         end
         assign regs[i] = q;
      end
   endgenerate

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
   assign rd3 = regs[ra3];

   a_r1_regs_cleared: assert property (@(posedge clk) rst |=> (rd3 == '0))
      else $error("register not cleared by reset");

endmodule

// File: rtl/dcore_wordmem.sv
module dcore_wordmem #(
   parameter int XLEN = 32,
   parameter int AW   = 6,
   localparam int WORDS = 1 << AW
)(
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   widx,
   input  logic [XLEN-1:0] wdata,
   input  logic [AW-1:0]   ridx_a,
   output logic [XLEN-1:0] rdata_a,
   input  logic [AW-1:0]   ridx_b,
   output logic [XLEN-1:0] rdata_b
);

   logic [XLEN-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we)
         mem[widx] <= wdata;
   end

   assign rdata_a = mem[ridx_a];
   assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/dual_op_core.sv
module dual_op_core
   import dcore_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int NREGS         = 32,
   parameter int MEM_AW        = 6,
   parameter bit STRICT_DECODE = 1'b1
)(
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      load_en,
   input  logic                      load_dmem,
   input  logic [MEM_AW-1:0]         load_idx,
   input  logic [XLEN-1:0]           load_word,
   output logic [XLEN-1:0]           dbg_pc,
   input  logic [$clog2(NREGS)-1:0]  dbg_reg_sel,
   output logic [XLEN-1:0]           dbg_reg_val,
   input  logic [MEM_AW-1:0]         dbg_mem_idx,
   output logic [XLEN-1:0]           dbg_mem_val,
   output logic [XLEN-1:0]           dbg_imem_val
);

   localparam int RW = $clog2(NREGS);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("dual_op_core: XLEN must be 32");
      end
      if (NREGS != 32) begin : g_bad_nregs
         $error("dual_op_core: NREGS must be 32 to match 5-bit fields");
      end
      if (MEM_AW < 1 || MEM_AW > 12) begin : g_bad_aw
         $error("dual_op_core: MEM_AW out of range");
      end
   endgenerate

   logic [XLEN-1:0] pc_q, pc_next, pc_plus4;
   logic [XLEN-1:0] instr;
   logic [XLEN-1:0] rs_val, rt_val;
   logic [XLEN-1:0] sext_imm, alu_b, alu_y;
   logic            alu_zero, alu_b_imm;
   dcore_ctrl_t     ctl;
   logic [XLEN-1:0] d_addr, d_rdata, wb_data;
   logic [MEM_AW-1:0] d_idx, dm_widx;
   logic            dm_we, im_we, rf_we;
   logic [XLEN-1:0] dm_wdata;

   // ---------------- fetch ----------------
   assign im_we = load_en & ~load_dmem;

   dcore_wordmem #(.XLEN(XLEN), .AW(MEM_AW)) u_imem (
      .clk(clk), .we(im_we), .widx(load_idx), .wdata(load_word),
      .ridx_a(pc_q[MEM_AW+1:2]), .rdata_a(instr),
      .ridx_b(dbg_mem_idx), .rdata_b(dbg_imem_val)
   );

   // ---------------- decode ----------------
   dcore_ctrl #(.STRICT_DECODE(STRICT_DECODE)) u_ctrl (
      .opcode(instr[31:26]), .zero(alu_zero),
      .alu_b_imm(alu_b_imm), .ctl(ctl)
   );

   assign rf_we   = ctl.rf_we & ~rst;
   assign wb_data = ctl.wb_from_mem ? d_rdata : rs_val;

   dcore_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
      .clk(clk), .rst(rst), .we(rf_we), .wa(RW'(fld_rd(instr))), .wd(wb_data),
      .ra1(RW'(fld_rs(instr))), .rd1(rs_val),
      .ra2(RW'(fld_rt(instr))), .rd2(rt_val),
      .ra3(dbg_reg_sel),        .rd3(dbg_reg_val)
   );

   // ---------------- execute ----------------
   assign sext_imm = {{(XLEN-16){instr[15]}}, instr[15:0]};
   assign alu_b    = alu_b_imm ? sext_imm : pc_q;

   dcore_alu #(.XLEN(XLEN)) u_alu (
      .a(rs_val), .b(alu_b), .sub(~alu_b_imm), .y(alu_y), .zero(alu_zero)
   );

   // ---------------- memory ----------------
   assign d_addr   = ctl.addr_from_reg ? rs_val : alu_y;
   assign d_idx    = d_addr[MEM_AW+1:2];
   assign dm_we    = (load_en & load_dmem) | (ctl.mem_we & ~rst);
   assign dm_widx  = load_en ? load_idx : d_idx;
   assign dm_wdata = load_en ? load_word : rt_val;

   dcore_wordmem #(.XLEN(XLEN), .AW(MEM_AW)) u_dmem (
      .clk(clk), .we(dm_we), .widx(dm_widx), .wdata(dm_wdata),
      .ridx_a(d_idx), .rdata_a(d_rdata),
      .ridx_b(dbg_mem_idx), .rdata_b(dbg_mem_val)
   );

   logic unused_addr_bits;
   assign unused_addr_bits = ^{d_addr[XLEN-1:MEM_AW+2], d_addr[1:0]};

   // ---------------- program counter ----------------
   assign pc_plus4 = pc_q + XLEN'(4);
   assign pc_next  = ctl.pc_from_reg ? rt_val : pc_plus4;

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_next;
   end

   assign dbg_pc = pc_q;

   a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc_q == '0))
      else $error("pc not zero after reset");

   a_r2_unknown_advances: assert property (@(posedge clk) disable iff (rst)
      ((instr[31:26] != OP_STORE) && (instr[31:26] != OP_PCCMP) && STRICT_DECODE)
         |=> (pc_q == $past(pc_q) + XLEN'(4)))
      else $error("unknown opcode did not advance pc by 4");

   a_r5_match_jumps: assert property (@(posedge clk) disable iff (rst)
      ((instr[31:26] == OP_PCCMP) && (rs_val == pc_q)) |=> (pc_q == $past(rt_val)))
      else $error("compare match did not jump to rt");

   a_r6_miss_advances: assert property (@(posedge clk) disable iff (rst)
      ((instr[31:26] == OP_PCCMP) && (rs_val != pc_q)) |=> (pc_q == $past(pc_q) + XLEN'(4)))
      else $error("compare miss did not advance pc by 4");

endmodule

// File: tb/tb_dual_op_core.sv
`timescale 1ns/1ps
module tb_dual_op_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_en = 1'b0;
   logic        load_dmem = 1'b0;
   logic [5:0]  load_idx = '0;
   logic [31:0] load_word = '0;
   logic [31:0] dbg_pc, dbg_reg_val, dbg_mem_val, dbg_imem_val;
   logic [4:0]  dbg_reg_sel = '0;
   logic [5:0]  dbg_mem_idx = '0;

   int checks = 0;
   int fails  = 0;

   logic [31:0] m_reg [32];
   logic [31:0] m_dm  [64];
   logic [31:0] m_im  [64];
   logic [31:0] m_pc;
   string       last_tag;

   always #2 clk = ~clk;

   dual_op_core dut (
      .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
      .load_idx(load_idx), .load_word(load_word), .dbg_pc(dbg_pc),
      .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
      .dbg_mem_idx(dbg_mem_idx), .dbg_mem_val(dbg_mem_val),
      .dbg_imem_val(dbg_imem_val)
   );

   localparam logic [31:0] NOP_WORD = 32'hFC00_0000;

   function automatic logic [31:0] enc_cmp(input int rd, input int rs, input int rt);
      return {6'b100000, 5'(rs), 5'(rt), 5'(rd), 11'd0};
   endfunction

   function automatic logic [31:0] enc_st(input int rs, input int rt, input logic [15:0] off);
      return {6'b000000, 5'(rs), 5'(rt), off};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic peek_reg(input int r, output logic [31:0] v);
      dbg_reg_sel = 5'(r);
      #0.01;
      v = dbg_reg_val;
   endtask

   task automatic peek_mem(input int i, output logic [31:0] v);
      dbg_mem_idx = 6'(i);
      #0.01;
      v = dbg_mem_val;
   endtask

   // compare whole architectural state; called at a falling edge
   task automatic check_all(input string req);
      logic [31:0] v;
      chk(req, "pc", dbg_pc, m_pc);
      for (int r = 0; r < 32; r++) begin
         peek_reg(r, v);
         chk(req, $sformatf("reg%0d", r), v, m_reg[r]);
      end
      for (int i = 0; i < 64; i++) begin
         peek_mem(i, v);
         chk(req, $sformatf("dmem%0d", i), v, m_dm[i]);
      end
   endtask

   // reference step from the requirements
   task automatic model_step();
      logic [31:0] ins, a, rsv, rtv, npc;
      int rs, rt, rd;
      ins = m_im[m_pc[7:2]];
      rs  = int'(ins[25:21]);
      rt  = int'(ins[20:16]);
      rd  = int'(ins[15:11]);
      rsv = m_reg[rs];
      rtv = m_reg[rt];
      npc = m_pc + 32'd4;
      if (ins[31:26] == 6'b000000) begin
         a = rsv + {{16{ins[15]}}, ins[15:0]};
         m_dm[a[7:2]] = rtv;
         last_tag = "R3";
      end else if (ins[31:26] == 6'b100000) begin
         if (rsv == m_pc) begin
            npc = rtv;
            if (rd != 0) m_reg[rd] = rsv;
            last_tag = "R5";
         end else begin
            if (rd != 0) m_reg[rd] = m_dm[rsv[7:2]];
            last_tag = "R6";
         end
      end else begin
         last_tag = "R2";
      end
      m_pc = npc;
   endtask

   // fills both memories while reset is held
   task automatic load_all();
      for (int i = 0; i < 128; i++) begin
         @(negedge clk);
         load_en   = 1'b1;
         load_dmem = (i >= 64);
         load_idx  = 6'(i % 64);
         load_word = (i >= 64) ? m_dm[i-64] : m_im[i];
      end
      @(negedge clk);
      load_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_steps(input int n);
      for (int k = 0; k < n; k++) begin
         model_step();
         @(negedge clk);
         check_all(last_tag);
      end
   endtask

   initial begin : watchdog
      #(4 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] v, pc_seen;
      void'($urandom(32'd2718));

      // ---------- directed program ----------
      for (int i = 0; i < 64; i++) begin
         m_im[i] = NOP_WORD;
         m_dm[i] = 32'(i * 4);
      end
      for (int r = 0; r < 32; r++) m_reg[r] = '0;
      m_pc = '0;
      m_dm[0] = 32'd16;
      m_dm[4] = 32'd36;
      m_im[1]  = enc_cmp(1, 0, 0);
      m_im[2]  = enc_cmp(2, 1, 0);
      m_im[3]  = enc_st(1, 2, 16'hFFFC);
      m_im[4]  = enc_cmp(3, 1, 2);
      m_im[9]  = enc_cmp(0, 1, 0);
      m_im[10] = enc_st(0, 3, 16'h0022);
      m_im[11] = {6'b100001, 5'd1, 5'd2, 5'd5, 11'd0};
      m_im[12] = {6'b000001, 5'd0, 5'd3, 16'd0};

      rst = 1'b1;
      load_all();
      check_all("R1");
      dbg_mem_idx = 6'd10;
      #0.01;
      chk("R8", "imem10 loaded", dbg_imem_val, m_im[10]);

      rst = 1'b0;
      run_steps(1);
      chk("R2", "pc after nop", dbg_pc, 32'd4);
      run_steps(2);
      peek_reg(1, v); chk("R6", "r1 loaded from dmem0", v, 32'd16);
      peek_reg(2, v); chk("R6", "r2 loaded from dmem4", v, 32'd36);
      run_steps(1);
      peek_mem(3, v); chk("R4", "negative offset store to word3", v, 32'd36);
      peek_reg(2, v); chk("R3", "store leaves rt unchanged", v, 32'd36);
      run_steps(1);
      pc_seen = dbg_pc;
      chk("R5", "pc jumps to rt", pc_seen, 32'd36);
      peek_reg(3, v); chk("R5", "rd gets rs on match", v, 32'd16);
      run_steps(1);
      peek_reg(0, v); chk("R7", "r0 stays zero after write", v, 32'd0);
      run_steps(1);
      peek_mem(8, v); chk("R8", "low address bits ignored", v, 32'd16);
      run_steps(1);
      peek_reg(5, v); chk("R2", "unknown opcode wrote no reg", v, 32'd0);
      chk("R2", "pc after unknown opcode", dbg_pc, 32'd48);
      run_steps(1);
      peek_mem(0, v); chk("R2", "unknown opcode wrote no memory", v, 32'd16);

      // ---------- reset after activity ----------
      @(negedge clk);
      rst = 1'b1;
      for (int r = 0; r < 32; r++) m_reg[r] = '0;
      m_pc = '0;
      @(negedge clk);
      check_all("R1");

      // ---------- constrained random program ----------
      for (int i = 0; i < 64; i++) begin
         int kind = int'($urandom % 10);
         int rs   = int'($urandom % 8);
         int rt   = int'($urandom % 8);
         int rd   = int'($urandom % 8);
         logic [15:0] off = 16'(int'($urandom % 64) - 32);
         if (kind < 5)      m_im[i] = enc_cmp(rd, rs, rt);
         else if (kind < 8) m_im[i] = enc_st(rs, rt, off);
         else               m_im[i] = {6'(($urandom % 31) + 1), 26'($urandom)};
         m_dm[i] = {24'd0, 6'($urandom), 2'b00};
      end
      load_all();
      check_all("R1");
      rst = 1'b0;
      run_steps(600);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule